// File: doc/BRIEF.md
# Clock-Recovery Lock Supervisor

This block supervises a single clock-recovery channel from the local reference clock domain. It counts recovered bit-clock edges over a fixed window of reference cycles. It compares that count with the count expected for the selected reference frequency. Separately, it watches the retimed serial data for runs of identical bits that are too long. From these checks it decides whether the channel may follow the recovered clock or must stay on the reference.

Three outputs come from that decision:
- a lock indicator;
- a mode select that tells the output clock multiplexer to use the reference-derived clock;
- an enable that gates the serial data passed downstream.

A low signal-detect input or an asserted (low) force-to-reference input overrides both checks. While the recovered rate stays outside the capture range, the lock indicator flips once per window instead of holding steady.

The recovered-clock count crosses into the reference domain as a Gray code. The run monitor's level and the two control inputs each pass through a two-flop synchronizer.

Top module: `cdr_lock_ctrl`

## Requirements
- R1: Within 4 reference cycles of `sd_i` going low, `lock_o` is 0, `ref_mode_o` is 1 and `data_en_o` is 0 (downstream data forced to zero). `data_en_o` returns to 1 when `sd_i` is high again.
- R2: Within 4 reference cycles of `lock_ref_n` going low, `lock_o` is 0 and `ref_mode_o` is 1. `data_en_o` keeps following `sd_i`.
- R3: A measurement window is 2^12 reference cycles. The expected recovered-clock count per window is 8·2^12 when `ref_sel`=0 and 3·2^12 when `ref_sel`=1.
- R4: A window is frequency-good when the count differs from the expected count by no more than ceil(expected·200/10^6), with a minimum of 1. This is 7 counts for `ref_sel`=0 and 3 counts for `ref_sel`=1.
- R5: `ref_mode_o` goes to 0 and `lock_o` to 1 only at the end of the second consecutive good window. One good window after a restart is not enough.
- R6: A run of 80 or more identical data bits drops lock within a few reference cycles (`lock_o`=0, `ref_mode_o`=1). Runs well below 80 bits leave an established lock untouched.
- R7: Each frequency-bad window inverts `lock_o` and keeps `ref_mode_o` at 1. Starting from 0, `lock_o` therefore reads 1, 0, 1, 0 after successive bad windows. A good window clears the flip.
- R8: While `rst` is high, `lock_o` is 0, `ref_mode_o` is 1 and `data_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Local reference clock; all control logic runs here |
| rst | input | 1 | Synchronous active-high reset |
| rec_clk | input | 1 | Recovered bit clock |
| rec_data | input | 1 | Retimed serial data, rec_clk domain |
| sd_i | input | 1 | Signal detect, active high, asynchronous |
| lock_ref_n | input | 1 | Force to reference, active low, asynchronous |
| ref_sel | input | 1 | Reference frequency select (0: ratio 8, 1: ratio 3), static |
| lock_o | output | 1 | Lock indicator |
| ref_mode_o | output | 1 | 1 = output clock follows the reference-derived clock |
| data_en_o | output | 1 | 1 = serial data passed downstream, 0 = forced to zero |

## Verification
The bench places the recovered clock just inside and just outside the 7-count tolerance at ratio 8. A wrongly rounded or wrongly signed tolerance either fails to lock or locks on a rate it should reject. It checks that the first good window alone does not lock, which catches a design that declares lock one window early. It drives an off-rate clock through four windows and expects the exact flip pattern, so a design that only drops lock, or flips without clearing, is exposed. It applies a short and a long run of identical bits while locked: an off-by-scale run limit either drops lock on harmless data or never drops it.

// File: rtl/cdrlk_pkg.sv
package cdrlk_pkg;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int i = 1; i < 32; i++) b = b ^ (g >> i);
    return b;
  endfunction

  // expected recovered edges in one window for a given reference select
  function automatic int unsigned exp_count(input logic sel, input int unsigned win_log2,
                                            input int unsigned ratio_lo, input int unsigned ratio_hi);
    return (sel ? ratio_hi : ratio_lo) << win_log2;
  endfunction

  // allowed deviation in counts: ceiling of exp*ppm/1e6, never below one
  function automatic int unsigned tol_count(input int unsigned expc, input int unsigned ppm);
    int unsigned t;
    t = (expc * ppm + 999_999) / 1_000_000;
    return (t == 0) ? 1 : t;
  endfunction

endpackage

// File: rtl/cdrlk_sync2.sv
module cdrlk_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/cdrlk_rec_side.sv
module cdrlk_rec_side #(
  parameter int CW        = 17,
  parameter int RUN_LIMIT = 80
) (
  input  logic          rec_clk,
  input  logic          rst_rec,
  input  logic          data,
  output logic [CW-1:0] gray_o,
  output logic          run_long_o
);
  import cdrlk_pkg::*;
  localparam int RW = $clog2(RUN_LIMIT + 1);

  logic [CW-1:0] bin_q, bin_nx;
  logic [RW-1:0] run_cnt;
  logic          prev_bit;

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge rec_clk) begin
    if (rst_rec) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= CW'(bin2gray(32'(bin_nx)));
    end
  end

  always_ff @(posedge rec_clk) begin
    if (rst_rec) begin
      prev_bit   <= 1'b0;
      run_cnt    <= '0;
      run_long_o <= 1'b0;
    end else begin
      prev_bit <= data;
      if (data != prev_bit) begin
        run_cnt    <= RW'(1);
        run_long_o <= 1'b0;
      end else begin
        if (run_cnt != RW'(RUN_LIMIT)) run_cnt <= run_cnt + 1'b1;
        run_long_o <= (run_cnt >= RW'(RUN_LIMIT - 1));
      end
    end
  end
endmodule

// File: rtl/cdrlk_window.sv
module cdrlk_window #(
  parameter int WIN_LOG2 = 12,
  parameter int CW       = 17,
  parameter int RATIO_LO = 8,
  parameter int RATIO_HI = 3,
  parameter int PPM      = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          ref_sel,
  input  logic [CW-1:0] gray_s,
  input  logic          run_s,
  output logic          win_end,
  output logic          freq_bad,
  output logic          run_bad
);
  import cdrlk_pkg::*;

  logic [WIN_LOG2-1:0] win_cnt;
  logic [CW-1:0]       cur_bin, base, delta;
  logic                run_seen;
  int unsigned         expc, tolc, span;

  assign cur_bin = CW'(gray2bin(32'(gray_s)));
  assign delta   = cur_bin - base;
  assign win_end = (win_cnt == '1) && !restart;

  always_comb begin
    expc = exp_count(ref_sel, WIN_LOG2, RATIO_LO, RATIO_HI);
    tolc = tol_count(expc, PPM);
    span = 32'(delta);
  end

  assign freq_bad = (span > expc + tolc) || (span + tolc < expc);
  assign run_bad  = run_seen || run_s;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      win_cnt  <= '0;
      base     <= cur_bin;
      run_seen <= 1'b0;
    end else begin
      win_cnt <= win_cnt + 1'b1;
      if (win_end) begin
        base     <= cur_bin;
        run_seen <= run_s;
      end else begin
        run_seen <= run_seen || run_s;
      end
    end
  end
endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl #(
  parameter int WIN_LOG2  = 12,
  parameter int RATIO_LO  = 8,
  parameter int RATIO_HI  = 3,
  parameter int PPM       = 200,
  parameter int RUN_LIMIT = 80,
  parameter int LOCK_WINS = 2
) (
  input  logic ref_clk,
  input  logic rst,
  input  logic rec_clk,
  input  logic rec_data,
  input  logic sd_i,
  input  logic lock_ref_n,
  input  logic ref_sel,
  output logic lock_o,
  output logic ref_mode_o,
  output logic data_en_o
);
  localparam int CW = WIN_LOG2 + 5;
  localparam int GW = $clog2(LOCK_WINS + 1);

  logic          rst_rec, sd_s, lref_s, run_s, run_long;
  logic [CW-1:0] gray_rec, gray_s;
  logic          forced, win_end, freq_bad, run_bad;
  logic          locked, flutter;
  logic [GW-1:0] good_cnt;

  cdrlk_sync2 #(.W(1)) u_rst_rec (.clk(rec_clk), .rst(1'b0), .d(rst), .q(rst_rec));
  cdrlk_sync2 #(.W(1)) u_sd      (.clk(ref_clk), .rst(rst), .d(sd_i), .q(sd_s));
  cdrlk_sync2 #(.W(1)) u_lref    (.clk(ref_clk), .rst(rst), .d(lock_ref_n), .q(lref_s));
  cdrlk_sync2 #(.W(1)) u_run     (.clk(ref_clk), .rst(rst), .d(run_long), .q(run_s));
  cdrlk_sync2 #(.W(CW)) u_gray   (.clk(ref_clk), .rst(rst), .d(gray_rec), .q(gray_s));

  cdrlk_rec_side #(.CW(CW), .RUN_LIMIT(RUN_LIMIT)) u_rec (
    .rec_clk(rec_clk), .rst_rec(rst_rec), .data(rec_data),
    .gray_o(gray_rec), .run_long_o(run_long)
  );

  assign forced = !sd_s || !lref_s;

  cdrlk_window #(.WIN_LOG2(WIN_LOG2), .CW(CW), .RATIO_LO(RATIO_LO),
                 .RATIO_HI(RATIO_HI), .PPM(PPM)) u_win (
    .clk(ref_clk), .rst(rst), .restart(forced), .ref_sel(ref_sel),
    .gray_s(gray_s), .run_s(run_s),
    .win_end(win_end), .freq_bad(freq_bad), .run_bad(run_bad)
  );

  always_ff @(posedge ref_clk) begin
    if (rst || forced) begin
      locked   <= 1'b0;
      flutter  <= 1'b0;
      good_cnt <= '0;
    end else if (run_s) begin
      locked   <= 1'b0;
      good_cnt <= '0;
    end else if (win_end) begin
      if (freq_bad) begin
        locked   <= 1'b0;
        good_cnt <= '0;
        flutter  <= !flutter;
      end else if (run_bad) begin
        locked   <= 1'b0;
        good_cnt <= '0;
      end else begin
        flutter <= 1'b0;
        if (good_cnt >= GW'(LOCK_WINS - 1)) locked <= 1'b1;
        else good_cnt <= good_cnt + 1'b1;
      end
    end
  end

  assign lock_o     = locked || flutter;
  assign ref_mode_o = !locked;
  assign data_en_o  = sd_s;
endmodule

// File: rtl/cdr_lock_ctrl_chk.sv
module cdr_lock_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic lref_s,
  input logic win_end,
  input logic freq_bad,
  input logic run_s,
  input logic lock_o,
  input logic ref_mode_o,
  input logic data_en_o
);
  AST_SD_LOW_NO_LOCK: assert property (@(posedge clk) disable iff (rst)
    !data_en_o |=> (!lock_o && ref_mode_o)); // R1
  AST_FORCE_REF: assert property (@(posedge clk) disable iff (rst)
    !lref_s |=> (!lock_o && ref_mode_o)); // R2
  AST_LOCK_AT_WIN_END: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_mode_o) |-> $past(win_end)); // R5
  AST_RUN_DROPS: assert property (@(posedge clk) disable iff (rst)
    run_s |=> ref_mode_o); // R6
  AST_BAD_WIN_REF: assert property (@(posedge clk) disable iff (rst)
    (win_end && freq_bad) |=> ref_mode_o); // R7
endmodule

bind cdr_lock_ctrl cdr_lock_ctrl_chk u_chk (
  .clk(ref_clk), .rst(rst), .lref_s(lref_s), .win_end(win_end),
  .freq_bad(freq_bad), .run_s(run_s), .lock_o(lock_o),
  .ref_mode_o(ref_mode_o), .data_en_o(data_en_o)
);

// File: tb/cdr_lock_ctrl_tb.sv
`timescale 1ps/100fs
module cdr_lock_ctrl_tb;
  localparam int  CLK_PERIOD = 48000;   // reference clock, ps
  localparam int  WIN        = 4096;    // R3 window length
  localparam real REC_NOM8   = 6000.0;  // ratio 8
  localparam real REC_NOM3   = 16000.0; // ratio 3

  logic ref_clk = 0, rec_clk = 0, rst = 1;
  logic rec_data = 0, sd_i = 1, lock_ref_n = 1, ref_sel = 0;
  logic lock_o, ref_mode_o, data_en_o;
  real  rec_per = REC_NOM8;
  int   hold_cnt = 0;
  int   checks = 0, errors = 0;
  bit   done = 0;

  cdr_lock_ctrl u_dut (
    .ref_clk(ref_clk), .rst(rst), .rec_clk(rec_clk), .rec_data(rec_data),
    .sd_i(sd_i), .lock_ref_n(lock_ref_n), .ref_sel(ref_sel),
    .lock_o(lock_o), .ref_mode_o(ref_mode_o), .data_en_o(data_en_o)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(rec_per/2.0) rec_clk = ~rec_clk;

  always @(negedge rec_clk) begin
    if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
    else rec_data <= ~rec_data;
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // force-pulse restart: window begins a few cycles after release
  task automatic restart_chan();
    lock_ref_n = 0;
    cycles(8);
    lock_ref_n = 1;
  endtask

  task automatic t_reset();
    cycles(3);
    check("R8", "lock", lock_o, 1'b0);
    check("R8", "ref_mode", ref_mode_o, 1'b1);
    check("R8", "data_en", data_en_o, 1'b0);
    rst = 0;
    cycles(5);
  endtask

  // R3 R5: ratio 8 locks after two windows, not one
  task automatic t_lock(input logic sel, input real per, input string req);
    ref_sel = sel;
    rec_per = per;
    restart_chan();
    cycles(WIN + 40);
    check("R5", "one window lock", lock_o, 1'b0);
    check("R5", "one window mode", ref_mode_o, 1'b1);
    cycles(WIN);
    check(req, "two window lock", lock_o, 1'b1);
    check(req, "two window mode", ref_mode_o, 1'b0);
  endtask

  // R4: just outside tolerance never locks
  task automatic t_out_of_tol();
    ref_sel = 0;
    rec_per = 6002.0;
    restart_chan();
    cycles(3 * WIN + 40);
    check("R4", "outside tol mode", ref_mode_o, 1'b1);
  endtask

  // R7: flip pattern across bad windows, then recovery
  task automatic t_flutter();
    ref_sel = 0;
    rec_per = 5900.0;
    restart_chan();
    cycles(WIN + 40);
    for (int k = 1; k <= 4; k++) begin
      check("R7", "flip value", lock_o, logic'(k % 2));
      check("R7", "flip mode", ref_mode_o, 1'b1);
      if (k < 4) cycles(WIN);
    end
    rec_per = REC_NOM8;
    cycles(3 * WIN + 40);
    check("R7", "recovered lock", lock_o, 1'b1);
    check("R7", "recovered mode", ref_mode_o, 1'b0);
  endtask

  // R6: short run harmless, long run drops
  task automatic t_runs();
    @(posedge rec_clk);
    hold_cnt = 60;
    cycles(40);
    check("R6", "short run lock", lock_o, 1'b1);
    cycles(WIN + 40);
    check("R6", "short run window", ref_mode_o, 1'b0);
    @(posedge rec_clk);
    hold_cnt = 150;
    cycles(40);
    check("R6", "long run lock", lock_o, 1'b0);
    check("R6", "long run mode", ref_mode_o, 1'b1);
  endtask

  task automatic t_sd();
    sd_i = 0;
    cycles(5);
    check("R1", "sd lock", lock_o, 1'b0);
    check("R1", "sd mode", ref_mode_o, 1'b1);
    check("R1", "sd data_en", data_en_o, 1'b0);
    sd_i = 1;
    cycles(5);
    check("R1", "sd data_en back", data_en_o, 1'b1);
  endtask

  task automatic t_force();
    lock_ref_n = 0;
    cycles(5);
    check("R2", "force lock", lock_o, 1'b0);
    check("R2", "force mode", ref_mode_o, 1'b1);
    check("R2", "force data_en", data_en_o, 1'b1);
    lock_ref_n = 1;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_lock(1'b0, REC_NOM8, "R3");
        t_sd();
        t_lock(1'b0, 6001.0, "R4");
        t_force();
        t_out_of_tol();
        t_lock(1'b1, REC_NOM3, "R3");
        t_flutter();
        t_runs();
        done = 1;
      end
      begin
        for (int i = 0; i < 190000 && !done; i++) @(negedge ref_clk);
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog actual=hung expected=done");
        end
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule